// File: doc/BRIEF.md
# Motor Lock Protection Timer

This block guards a three-phase brushless drive against a stalled rotor. While the motor is being driven it watches the three Hall sensor bits. Each time the Hall code changes, a timeout counter goes back to zero. The counter advances by one on every PWM-period tick. If the counter reaches a programmed number of ticks with no Hall change, the block latches a lock fault and forces the low-side switches off. The high-side switches are not affected.

The counter stands in for a charging timing capacitor. During stop it counts down by a fixed step per tick instead of clearing at once. A short stop therefore leaves a residue, and the next timeout is shorter than the programmed value.

Three events clear the fault:
- entering stop mode;
- a run of more than `ZERO_RUN` consecutive PWM periods at zero duty;
- reset.

Brake suspends detection. A strap input disables detection altogether.

Top module: `mlock_timer`

## Requirements
- R1: The Hall bits pass through a two-flop synchronizer. A Hall code change seen while driving (not stopped, not braking) returns the counter to zero, so a full `timeout` ticks are again needed.
- R2: With detection enabled, driving, and no Hall change, `lock_fault` rises on exactly the `timeout`-th `pwm_tick` counted from zero. It is set one clock after that tick.
- R3: `lowside_off` equals `lock_fault`. The fault stays latched until one of the release events in R4, R5 or R6.
- R4: One clock with `stop_req` high clears `lock_fault`.
- R5: When `pwm_tick` arrives with `duty_zero` high for the (`ZERO_RUN`+1)-th consecutive time, `lock_fault` clears and the counter returns to zero. A tick with `duty_zero` low restarts the run from zero.
- R6: Asynchronous active-low reset clears `lock_fault` and the counter.
- R7: While `brake_req` is high (and `stop_req` low), the counter holds its value and `lock_fault` does not rise.
- R8: With `det_en` low, `lock_fault` never rises.
- R9: During stop, each `pwm_tick` lowers the counter by `DISCH_STEP`, stopping at zero. After the stop ends, only the remaining `timeout` minus counter ticks are needed to fault.
- R10: The counter changes only on clocks where `pwm_tick` is high. Hall changes and zero-duty release are the exceptions, since they clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | One-clock pulse per PWM period |
| hall | input | 3 | Raw Hall sensor bits |
| stop_req | input | 1 | Stop mode active |
| brake_req | input | 1 | Brake active |
| duty_zero | input | 1 | Current PWM period has 0% duty |
| det_en | input | 1 | Lock detection enable strap |
| timeout | input | CNT_W | Lock timeout in PWM ticks |
| lock_fault | output | 1 | Latched lock fault |
| lowside_off | output | 1 | Force low-side switches off |

## Verification
The bench sweeps every small timeout from 1 to 8. It checks that the fault appears on the exact tick and not one tick early. An off-by-one compare would fault early or late.

Other checks each target a likely mistake:
- **Mid-count Hall change.** A design that ignored the synchronized edge would fault too soon after the change.
- **Zero-duty release boundary.** The bench checks the eighth and ninth zero-duty ticks, and also a run broken by one nonzero period. A release that fires at eight ticks, or does not reset the run, is caught.
- **Partial discharge.** A partial and a full stop are followed by counting the remaining ticks. A stop that cleared the counter outright, or did not saturate at zero, gives the wrong remaining count.
- **Brake, strap and tick gating.** These show a counter that kept counting when it must hold.

// File: rtl/mlock_timer.sv
module mlock_timer #(
  parameter int CNT_W      = 16,
  parameter int DISCH_STEP = 4,
  parameter int ZERO_RUN   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_tick,
  input  logic [2:0]       hall,
  input  logic             stop_req,
  input  logic             brake_req,
  input  logic             duty_zero,
  input  logic             det_en,
  input  logic [CNT_W-1:0] timeout,
  output logic             lock_fault,
  output logic             lowside_off
);
  localparam int ZW = $clog2(ZERO_RUN + 2);

  logic [2:0]       h_s1, h_s2, h_prev;
  logic [CNT_W-1:0] cnt;
  logic [ZW-1:0]    zrun;
  logic [CNT_W:0]   cnt_inc;
  logic             hall_edge, zero_idle, zero_release;

  assign hall_edge    = h_s2 != h_prev;
  assign cnt_inc      = {1'b0, cnt} + 1'b1;
  assign zero_idle    = zrun == ZW'(ZERO_RUN + 1);
  assign zero_release = pwm_tick && duty_zero && zrun == ZW'(ZERO_RUN);
  assign lowside_off  = lock_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_s1       <= '0;
      h_s2       <= '0;
      h_prev     <= '0;
      cnt        <= '0;
      zrun       <= '0;
      lock_fault <= 1'b0;
    end else begin
      h_s1   <= hall;
      h_s2   <= h_s1;
      h_prev <= h_s2;
      if (stop_req) begin
        lock_fault <= 1'b0;
        zrun       <= '0;
        if (pwm_tick)
          cnt <= (cnt > CNT_W'(DISCH_STEP)) ? cnt - CNT_W'(DISCH_STEP) : '0;
      end else begin
        if (pwm_tick)
          zrun <= duty_zero ? (zero_idle ? zrun : zrun + 1'b1) : '0;
        if (zero_release) begin
          lock_fault <= 1'b0;
          cnt        <= '0;
        end else if (!brake_req) begin
          if (hall_edge || zero_idle)
            cnt <= '0;
          else if (pwm_tick && !lock_fault) begin
            if (cnt < timeout)
              cnt <= cnt_inc[CNT_W-1:0];
            if (det_en && cnt_inc >= {1'b0, timeout})
              lock_fault <= 1'b1;
          end
        end
      end
    end
  end

  a_r8_strap_blocks_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !lock_fault) |=> !lock_fault);

  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !lock_fault);

  a_r7_brake_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_req && !stop_req && !zero_release) |=> (cnt == $past(cnt) && !$rose(lock_fault)));

  a_r10_fault_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_fault) |-> $past(pwm_tick));

  a_r9_discharge_down: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && pwm_tick) |=> cnt <= $past(cnt));
endmodule

// File: tb/mlock_timer_bench.sv
module mlock_timer_bench;
  localparam int CW = 6;
  localparam int DS = 2;
  localparam int ZR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_tick = 1'b0, stop_req = 1'b0, brake_req = 1'b0, duty_zero = 1'b0, det_en = 1'b1;
  logic [2:0] hall = 3'b001;
  logic [CW-1:0] timeout = 6'd3;
  logic lock_fault, lowside_off;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mlock_timer #(.CNT_W(CW), .DISCH_STEP(DS), .ZERO_RUN(ZR)) u_mlock_timer (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .hall(hall),
    .stop_req(stop_req), .brake_req(brake_req), .duty_zero(duty_zero),
    .det_en(det_en), .timeout(timeout), .lock_fault(lock_fault), .lowside_off(lowside_off));

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pwm_tick = 1'b1;
      @(negedge clk) pwm_tick = 1'b0;
    end
  endtask

  task automatic do_reset(int t);
    @(negedge clk);
    rst_n = 1'b0; stop_req = 0; brake_req = 0; duty_zero = 0; det_en = 1; pwm_tick = 0;
    hall = 3'b001; timeout = CW'(t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(3);
    chk("R6 reset fault", lock_fault, 1'b0);
    chk("R6 reset lowside", lowside_off, 1'b0);

    for (int t = 1; t <= 8; t++) begin
      do_reset(t);
      tick(t - 1);
      chk("R2 no fault before timeout", lock_fault, 1'b0);
      tick(1);
      chk("R2 fault at timeout", lock_fault, 1'b1);
      chk("R3 lowside follows", lowside_off, 1'b1);
      repeat (10) @(negedge clk);
      chk("R3 fault held", lock_fault, 1'b1);
    end

    do_reset(1);
    repeat (50) @(negedge clk);
    chk("R10 no advance without tick", lock_fault, 1'b0);
    tick(1);
    chk("R10 single tick faults", lock_fault, 1'b1);
    rst_n = 1'b0; @(negedge clk);
    chk("R6 async reset clears", lock_fault, 1'b0);

    do_reset(5);
    tick(3);
    hall = 3'b011;
    repeat (4) @(negedge clk);
    tick(4);
    chk("R1 hall edge restarts count", lock_fault, 1'b0);
    tick(1);
    chk("R1 fault full timeout after edge", lock_fault, 1'b1);

    do_reset(3);
    tick(3);
    stop_req = 1'b1; @(negedge clk);
    chk("R4 stop clears fault", lock_fault, 1'b0);
    chk("R4 stop clears lowside", lowside_off, 1'b0);
    stop_req = 1'b0;

    do_reset(3);
    tick(3);
    duty_zero = 1'b1;
    tick(ZR);
    chk("R5 eight zero periods keep fault", lock_fault, 1'b1);
    tick(1);
    chk("R5 ninth zero period clears", lock_fault, 1'b0);

    do_reset(3);
    tick(3);
    duty_zero = 1'b1; tick(5);
    duty_zero = 1'b0; tick(1);
    duty_zero = 1'b1; tick(ZR);
    chk("R5 broken run keeps fault", lock_fault, 1'b1);
    tick(1);
    chk("R5 restarted run clears", lock_fault, 1'b0);
    duty_zero = 1'b0;

    do_reset(10);
    tick(8);
    stop_req = 1'b1; tick(2); stop_req = 1'b0;
    tick(5);
    chk("R9 partial discharge not yet", lock_fault, 1'b0);
    tick(1);
    chk("R9 shortened timeout", lock_fault, 1'b1);

    do_reset(10);
    tick(8);
    stop_req = 1'b1; tick(6); stop_req = 1'b0;
    tick(9);
    chk("R9 full discharge no early fault", lock_fault, 1'b0);
    tick(1);
    chk("R9 full discharge full timeout", lock_fault, 1'b1);

    do_reset(6);
    tick(3);
    brake_req = 1'b1; tick(10);
    chk("R7 no fault during brake", lock_fault, 1'b0);
    brake_req = 1'b0;
    tick(2);
    chk("R7 counter held in brake", lock_fault, 1'b0);
    tick(1);
    chk("R7 resumes after brake", lock_fault, 1'b1);

    do_reset(3);
    det_en = 1'b0;
    tick(12);
    chk("R8 strap off no fault", lock_fault, 1'b0);
    chk("R8 strap off lowside", lowside_off, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule